// File: doc/BRIEF.md
# PHY Management Register Model

This block gives a host a single 32-bit management register through which it can issue reads and writes to the registers of up to 32 PHYs, without any serial management wire behind it. A built-in model answers every access. The host writes a command word that holds an opcode, a PHY address, a register address and a 16-bit data field. A write-opcode command puts its data into a per-PHY register store. A read-opcode command makes the next host read return the command word with its data field filled in from the model.

The model returns stored values for most registers. A handful of identity and capability registers always answer with fixed constants, and the basic control register has some of its bits masked and one bit forced. Every access completes at once, so the returned word always shows the ready bit set. The store is a synchronous RAM, which makes a host read answer exactly one cycle after it is requested. An optional one-cycle completion pulse lets a neighbouring status block record that a management access finished.

Top module: `mgmt_phy_regmodel`

## Requirements
- R1: A host write captures all 32 bits of the command word. A later host read returns that word unchanged apart from bit 28, and apart from the data field when the opcode is read.
- R2: Command word fields are: bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Opcode 1 writes the data field into the store entry at (PHY, register). Opcodes 0 and 3 leave the store untouched.
- R3: A host read that is accepted in cycle N gives host_rvalid high in cycle N+1 only. Reads held on consecutive cycles give a response in each following cycle.
- R4: When the captured opcode is 2 (read), the data field of the returned word holds the model value of the selected PHY register.
- R5: Bit 28 (ready) is set in every returned word. Bits 31:29 and 27:16 are returned exactly as written, including bit 29 (interrupt enable).
- R6: Register 0 reads back as its stored value with bits 15 and 9 cleared and bit 13 set. After reset this gives 0x2000.
- R7: Whatever was stored, register 1 reads 0x782C, register 2 reads 0x0013, register 3 reads 0x61D4, register 5 reads 0x41E1, register 6 reads 0x0001 and register 17 reads 0x4700.
- R8: Every other register returns the last value written to that same (PHY, register) pair. Entries of different PHYs and different registers do not affect each other, and all entries read zero after reset.
- R9: With DONE_EN set, op_done is high for one cycle in the cycle after a host write whose opcode is 1, and in the cycle of a read response whose opcode is 2. It stays low for any other access.
- R10: After reset host_rvalid and op_done are low. host_rdata is zero in every cycle where host_rvalid is low.
- R11: If host_wr and host_rd are both high in the same cycle, the write is taken and the read is dropped, so no response follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the command register |
| host_wdata | input | 32 | Command word written by the host |
| host_rd | input | 1 | Host read request for the command register |
| host_rdata | output | 32 | Returned command word, valid with host_rvalid |
| host_rvalid | output | 1 | Read response valid, one cycle after an accepted read |
| op_done | output | 1 | One-cycle completion pulse for a management read or write |

## Verification
A vector table walks every opcode against stored registers, the overridden identity registers and the masked control register. This separates a store that answers from a model that substitutes a fixed value, and it shows that the opcodes 0 and 3 change neither the store nor the returned data. Writes to neighbouring PHYs and registers, followed by reads of the other entries, expose address aliasing or a swapped PHY and register field. Directed sequences cover reset zeroing, back-to-back reads, a write and a read in the same cycle, and the completion pulse, which must fire for the right opcodes only.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int STORE_AW = PHY_AW + REG_AW;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_OTHER = 2'd3
    } mdi_op_e;

    typedef struct packed {
        logic [1:0]        spare;
        logic              irq_en;
        logic              ready;
        mdi_op_e           op;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regno;
        logic [DATA_W-1:0] data;
    } mdi_cmd_t;

    localparam logic [DATA_W-1:0] CTRL_CLR_BITS = 16'h8200;
    localparam logic [DATA_W-1:0] CTRL_SET_BITS = 16'h2000;
    localparam logic [DATA_W-1:0] VAL_STATUS    = 16'h782C;
    localparam logic [DATA_W-1:0] VAL_ID_HI     = 16'h0013;
    localparam logic [DATA_W-1:0] VAL_ID_LO     = 16'h61D4;
    localparam logic [DATA_W-1:0] VAL_PARTNER   = 16'h41E1;
    localparam logic [DATA_W-1:0] VAL_EXPANSION = 16'h0001;
    localparam logic [DATA_W-1:0] VAL_VENDOR17  = 16'h4700;

    function automatic logic [DATA_W-1:0] phy_view(
        input logic [REG_AW-1:0] regno,
        input logic [DATA_W-1:0] stored
    );
        logic [DATA_W-1:0] v;
        case (regno)
            5'd0:    v = (stored & ~CTRL_CLR_BITS) | CTRL_SET_BITS;
            5'd1:    v = VAL_STATUS;
            5'd2:    v = VAL_ID_HI;
            5'd3:    v = VAL_ID_LO;
            5'd5:    v = VAL_PARTNER;
            5'd6:    v = VAL_EXPANSION;
            5'd17:   v = VAL_VENDOR17;
            default: v = stored;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  written_q;
    logic [DATA_W-1:0] dout_q;
    logic              hit_q;

    // RAM array: no reset, one-cycle read latency
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            dout_q <= mem[raddr];
        end
    end

    // Per-entry written flags make the whole store read zero after reset
    always_ff @(posedge clk) begin
        if (rst) begin
            written_q <= '0;
            hit_q     <= 1'b0;
        end else begin
            if (we) begin
                written_q[waddr] <= 1'b1;
            end
            if (re) begin
                hit_q <= written_q[raddr];
            end
        end
    end

    assign rdata = hit_q ? dout_q : '0;

    // R8: a read of an entry never written since reset answers zero
    p_unwritten_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (re && !written_q[raddr] && !we) |=> (rdata == '0));

endmodule

// File: rtl/phy_read_view.sv
module phy_read_view
    import mgmt_phy_pkg::*;
(
    input  logic [REG_AW-1:0] regno,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] view
);
    assign view = phy_view(regno, stored);

    // R7: identity registers never pass the stored value through
    always_comb begin
        if (regno == 5'd2) begin
            a_fixed_id_r7: assert (view == VAL_ID_HI);
        end
    end

endmodule

// File: rtl/mgmt_phy_regmodel.sv
module mgmt_phy_regmodel
    import mgmt_phy_pkg::*;
#(
    parameter bit DONE_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    input  logic        host_rd,
    output logic [31:0] host_rdata,
    output logic        host_rvalid,
    output logic        op_done
);
    mdi_cmd_t          ctrl_q;
    mdi_cmd_t          wr_cmd;
    mdi_cmd_t          resp;
    logic              rd_accept;
    logic              rd_pend_q;
    logic              store_we;
    logic              store_re;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] view_data;

    assign wr_cmd    = mdi_cmd_t'(host_wdata);
    assign rd_accept = host_rd && !host_wr;
    assign store_we  = host_wr && (wr_cmd.op == OP_WRITE);
    assign store_re  = rd_accept && (ctrl_q.op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= rd_accept;
            if (host_wr) begin
                ctrl_q <= wr_cmd;
            end else if (rd_pend_q && (ctrl_q.op == OP_READ)) begin
                ctrl_q.data <= view_data;
            end
        end
    end

    phy_reg_store #(
        .ADDR_W (STORE_AW),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .waddr ({wr_cmd.phy, wr_cmd.regno}),
        .wdata (wr_cmd.data),
        .re    (store_re),
        .raddr ({ctrl_q.phy, ctrl_q.regno}),
        .rdata (store_rdata)
    );

    phy_read_view u_view (
        .regno  (ctrl_q.regno),
        .stored (store_rdata),
        .view   (view_data)
    );

    always_comb begin
        resp       = ctrl_q;
        resp.ready = 1'b1;
        if (ctrl_q.op == OP_READ) begin
            resp.data = view_data;
        end
    end

    assign host_rvalid = rd_pend_q;
    assign host_rdata  = rd_pend_q ? 32'(resp) : 32'd0;

    generate
        if (DONE_EN) begin : g_done
            logic done_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    done_q <= 1'b0;
                end else begin
                    done_q <= store_we || store_re;
                end
            end
            assign op_done = done_q;

            // R9: a pulse follows a write-opcode write or comes with a response
            p_done_cause_r9: assert property (@(posedge clk) disable iff (rst)
                op_done |-> ($past(host_wr) || host_rvalid));
        end else begin : g_no_done
            assign op_done = 1'b0;
        end
    endgenerate

    // R3: a response only follows an accepted read
    p_rvalid_follows_rd_r3: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_rd && !host_wr));

    // R11: a read beside a write yields no response
    p_collision_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_wr) |=> !host_rvalid);

    // R5: ready bit in every response
    p_ready_set_r5: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> host_rdata[28]);

    // R10: no stale data on the read bus
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !host_rvalid |-> (host_rdata == 32'd0));

    // R6: control register masking and forcing
    p_ctrl_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && host_rdata[27:26] == 2'd2 && host_rdata[20:16] == 5'd0)
        |-> (!host_rdata[15] && !host_rdata[9] && host_rdata[13]));

    // R7: fixed vendor register value
    p_fixed_vendor_r7: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && host_rdata[27:26] == 2'd2 && host_rdata[20:16] == 5'd17)
        |-> (host_rdata[15:0] == 16'h4700));

endmodule

// File: tb/mgmt_phy_regmodel_test.sv
`timescale 1ns/1ps
module mgmt_phy_regmodel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = 32'd0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        op_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mgmt_phy_regmodel #(.DONE_EN(1'b1)) uut (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .op_done     (op_done)
    );

    // Each row: command word written, then the word a following read returns
    localparam int NV = 29;
    localparam logic [31:0] VEC_CMD [NV] = '{
        32'h0804FFFF, 32'h08600000, 32'h0460FFFF, 32'h08600000, 32'h04600200,
        32'h08600000, 32'h04E11234, 32'h08E10000, 32'h0802AAAA, 32'h0BE30000,
        32'h08850000, 32'h08860000, 32'h08910000, 32'h2524BEEF, 32'h05441111,
        32'h09240000, 32'h09440000, 32'h0D245555, 32'h01246666, 32'h09240000,
        32'h07FFC0DE, 32'h2BFF0000, 32'h04508001, 32'h08500000, 32'h04511234,
        32'h08510000, 32'hC00000FF, 32'h08040000, 32'h08000000
    };
    localparam logic [31:0] VEC_EXP [NV] = '{
        32'h18040000, 32'h18602000, 32'h1460FFFF, 32'h18607DFF, 32'h14600200,
        32'h18602000, 32'h14E11234, 32'h18E1782C, 32'h18020013, 32'h1BE361D4,
        32'h188541E1, 32'h18860001, 32'h18914700, 32'h3524BEEF, 32'h15441111,
        32'h1924BEEF, 32'h19441111, 32'h1D245555, 32'h11246666, 32'h1924BEEF,
        32'h17FFC0DE, 32'h3BFFC0DE, 32'h14508001, 32'h18508001, 32'h14511234,
        32'h18514700, 32'hD00000FF, 32'h18040000, 32'h18002000
    };

    function automatic string row_req(input int i);
        case (i)
            0, 27:          return "R8";
            1, 3, 5, 28:    return "R6";
            2, 4, 6, 14:    return "R1";
            7, 8, 9, 10, 11, 12, 25: return "R7";
            13, 21, 26:     return "R5";
            17, 18, 19:     return "R2";
            default:        return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic do_read(output logic [31:0] d, output logic v, output logic dn);
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d  = host_rdata;
        v  = host_rvalid;
        dn = op_done;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd_word;
        logic        rd_v;
        logic        rd_dn;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check("R10 rvalid after reset", {31'd0, host_rvalid}, 32'd0);
        check("R10 rdata after reset", host_rdata, 32'd0);
        check("R10 done after reset", {31'd0, op_done}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_write(VEC_CMD[i]);
            do_read(rd_word, rd_v, rd_dn);
            check({row_req(i), " row rvalid (R3)"}, {31'd0, rd_v}, 32'd1);
            check({row_req(i), " row data"}, rd_word, VEC_EXP[i]);
        end

        // R10: bus returns to zero once the response cycle is over
        @(negedge clk);
        check("R10 idle rvalid", {31'd0, host_rvalid}, 32'd0);
        check("R10 idle rdata", host_rdata, 32'd0);

        // R9: pulse after a write-opcode write, none after opcode 0
        do_write(32'h04A74242);
        check("R9 done after write op", {31'd0, op_done}, 32'd1);
        @(negedge clk);
        check("R9 done is one cycle", {31'd0, op_done}, 32'd0);
        do_write(32'h00A70000);
        check("R9 no done for op0 write", {31'd0, op_done}, 32'd0);
        do_read(rd_word, rd_v, rd_dn);
        check("R9 no done for op0 read", {31'd0, rd_dn}, 32'd0);

        // R11: simultaneous write and read
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = 32'h08A70000;
        host_rd    = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
        check("R11 read dropped", {31'd0, host_rvalid}, 32'd0);
        check("R9 no done for collision", {31'd0, op_done}, 32'd0);
        do_read(rd_word, rd_v, rd_dn);
        check("R11 write taken", rd_word, 32'h18A74242);
        check("R9 done with read response", {31'd0, rd_dn}, 32'd1);

        // R3: reads held on two consecutive cycles
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        check("R3 first back-to-back rvalid", {31'd0, host_rvalid}, 32'd1);
        check("R4 first back-to-back data", host_rdata, 32'h18A74242);
        @(negedge clk);
        host_rd = 1'b0;
        check("R3 second back-to-back rvalid", {31'd0, host_rvalid}, 32'd1);
        check("R4 second back-to-back data", host_rdata, 32'h18A74242);
        @(negedge clk);
        check("R3 rvalid drops", {31'd0, host_rvalid}, 32'd0);

        // R8: reset clears stored entries
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_write(32'h09240000);
        do_read(rd_word, rd_v, rd_dn);
        check("R8 entry zero after reset", rd_word, 32'h19240000);
        do_write(32'h08A70000);
        do_read(rd_word, rd_v, rd_dn);
        check("R8 second entry zero after reset", rd_word, 32'h18A70000);

        finish_run();
    end

endmodule